// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the digital control that sits around a successive-approximation converter. It picks one of five start events with a 3-bit select code and runs the timing from that event through tracking and conversion. It then reports a busy level and a sticky completion flag. A per-cycle SAR clock enable paces all timing. A counter of programmable length stands in for the analog conversion itself.

There are two tracking policies. In normal policy the input is tracked whenever the block is enabled and idle, and a start event goes straight to conversion. In low-power policy a start event opens a tracking burst of exactly three SAR clock enables, and conversion follows on its own. The exception is the external-pin select, where tracking follows the pin being low and conversion begins on its rising edge. The pin is brought through a two-flop synchronizer. Start events that arrive during a burst or a conversion are dropped, not held.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, track, convert, busy and done are all 0.
- R2: While en is 0, track and busy stay 0, and no start event begins a burst or a conversion.
- R3: start_sel chooses the start event: 3'b000 a software busy write with data 1, 3'b001 tmr3_ovf, 3'b010 a rising edge of the synchronized ext_start, 3'b011 tmr2_ovf, 3'b1xx peer_start. A pulse on any source that is not selected has no effect.
- R4: A busy write with busy_wdata 0 has no effect. A busy write with data 1 starts nothing unless start_sel is 3'b000.
- R5: With lp_mode 0, track is 1 whenever en is 1 and no conversion runs. A selected event makes busy 1 from the next clock edge on.
- R6: A conversion lasts CONV_CLKS SAR clock enables. busy falls at the edge that takes the last of them, and done becomes 1 at that same edge.
- R7: With lp_mode 1 and start_sel other than 3'b010, an event makes track 1 for exactly three SAR clock enables. busy and convert then rise at the edge that takes the third one.
- R8: With lp_mode 1 and start_sel 3'b010, track equals the inverse of the synchronized pin while idle. The pin passes two flops, so a rise before edge k drops track after edge k+1 and starts the conversion at edge k+2.
- R9: done stays 1 until a done_clr pulse. A done_clr in the same cycle as a completion leaves done at 1.
- R10: Start events during a burst or conversion are ignored and are not queued. busy stays 0 in the cycle after a completion, even if events arrived while busy was high.
- R11: convert is a one-cycle pulse in the first cycle of every conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| lp_mode | input | 1 | 1 selects low-power tracking policy |
| start_sel | input | 3 | Start event select |
| busy_we | input | 1 | Software write strobe to the busy bit |
| busy_wdata | input | 1 | Data of that write |
| peer_start | input | 1 | Software start shared with the second converter |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| ext_start | input | 1 | Asynchronous external convert-start pin |
| sar_ce | input | 1 | SAR clock enable |
| done_clr | input | 1 | Software clear of the completion flag |
| track | output | 1 | Sample-and-hold is tracking |
| convert | output | 1 | Conversion start strobe |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky conversion-complete flag |

## Verification
Software, timer and peer events show up on busy and convert one edge after the cycle in which they are driven. A pin rise reaches busy two edges later, after the synchronizer. A burst moves into conversion at the edge that takes the third SAR enable. busy and done switch together at the edge that takes the last conversion enable. The bench drives inputs on the falling edge and samples on the next falling edge. A cycle model in the bench is advanced on the rising edge, so every comparison sits exactly one edge after its stimulus. Directed sequences count the cycles listed above with sar_ce held high, so the expected values follow directly from the counts.

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int CONV_CLKS  = 16,
  parameter int TRACK_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       lp_mode,
  input  logic [2:0] start_sel,
  input  logic       busy_we,
  input  logic       busy_wdata,
  input  logic       peer_start,
  input  logic       tmr3_ovf,
  input  logic       tmr2_ovf,
  input  logic       ext_start,
  input  logic       sar_ce,
  input  logic       done_clr,
  output logic       track,
  output logic       convert,
  output logic       busy,
  output logic       done
);
  localparam int MAXC = (CONV_CLKS > TRACK_CLKS) ? CONV_CLKS : TRACK_CLKS;
  localparam int CW   = $clog2(MAXC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_CONV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          cv;
  logic          pin_s1, pin_s2, pin_q;
  logic          pin_rise, pin_mode, trig, fin;

  always_ff @(posedge clk) begin
    if (!rst_n) {pin_s1, pin_s2, pin_q} <= '0;
    else        {pin_s1, pin_s2, pin_q} <= {ext_start, pin_s1, pin_s2};
  end

  assign pin_rise = pin_s2 & ~pin_q;
  assign pin_mode = lp_mode && start_sel == 3'b010;

  always_comb begin
    if (start_sel[2]) trig = peer_start;
    else begin
      unique case (start_sel[1:0])
        2'd0:    trig = busy_we & busy_wdata;
        2'd1:    trig = tmr3_ovf;
        2'd2:    trig = pin_rise;
        default: trig = tmr2_ovf;
      endcase
    end
  end

  assign fin = en && st == S_CONV && sar_ce && cnt == CW'(CONV_CLKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      cv <= 1'b0;
    end else begin
      cv <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          S_IDLE:
            if (trig) begin
              cnt <= '0;
              if (lp_mode && !pin_mode) st <= S_TRACK;
              else begin
                st <= S_CONV;
                cv <= 1'b1;
              end
            end
          S_TRACK:
            if (sar_ce) begin
              if (cnt == CW'(TRACK_CLKS - 1)) begin
                st <= S_CONV;
                cnt <= '0;
                cv <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end
          default:
            if (sar_ce) begin
              if (fin) begin
                st <= S_IDLE;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin | (done & ~done_clr);
  end

  assign busy    = st == S_CONV;
  assign convert = cv;
  assign track   = en & (lp_mode ? (pin_mode ? (st == S_IDLE & ~pin_s2) : st == S_TRACK)
                                 : st != S_CONV);

  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy && !convert);
  // R2
  disabled_notrack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !track);
  // R6
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(en) |-> done);
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_clr |=> done);
  // R11
  convert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convert |-> busy ##1 !convert);
  // R11
  convert_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> convert);
  // R5
  normal_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !lp_mode && !busy |-> track);
endmodule

// File: tb/adc_trig_seq_test.sv
`timescale 1ns/1ps
module adc_trig_seq_test;
  localparam int CONV_CLKS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, lp_mode = 0, busy_we = 0, busy_wdata = 0, peer_start = 0;
  logic tmr3_ovf = 0, tmr2_ovf = 0, ext_start = 0, sar_ce = 0, done_clr = 0;
  logic [2:0] start_sel = 3'b000;
  logic track, convert, busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_trig_seq #(.CONV_CLKS(CONV_CLKS), .TRACK_CLKS(3)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .lp_mode(lp_mode), .start_sel(start_sel),
    .busy_we(busy_we), .busy_wdata(busy_wdata), .peer_start(peer_start),
    .tmr3_ovf(tmr3_ovf), .tmr2_ovf(tmr2_ovf), .ext_start(ext_start),
    .sar_ce(sar_ce), .done_clr(done_clr),
    .track(track), .convert(convert), .busy(busy), .done(done));

  // cycle model built from the requirements
  int m_st = 0, m_cnt = 0;
  logic m_s1 = 0, m_s2 = 0, m_q = 0, m_cv = 0, m_done = 0;

  function automatic logic sel_event(logic [2:0] s, logic rise);
    if (s[2]) return peer_start;
    case (s[1:0])
      2'd0: return busy_we & busy_wdata;
      2'd1: return tmr3_ovf;
      2'd2: return rise;
      default: return tmr2_ovf;
    endcase
  endfunction

  function automatic logic exp_track();
    if (!en) return 0;
    if (!lp_mode) return m_st != 2;
    if (start_sel == 3'b010) return m_st == 0 && !m_s2;
    return m_st == 1;
  endfunction

  always @(posedge clk) begin
    logic ev, fin;
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_cv <= 0; m_done <= 0; m_s1 <= 0; m_s2 <= 0; m_q <= 0;
    end else begin
      ev  = sel_event(start_sel, m_s2 & ~m_q);
      fin = en && m_st == 2 && sar_ce && m_cnt == CONV_CLKS - 1;
      m_s1 <= ext_start; m_s2 <= m_s1; m_q <= m_s2;
      m_done <= fin | (m_done & ~done_clr);
      m_cv <= 0;
      if (!en) begin m_st <= 0; m_cnt <= 0; end
      else if (m_st == 0) begin
        if (ev) begin
          m_cnt <= 0;
          if (lp_mode && start_sel != 3'b010) m_st <= 1;
          else begin m_st <= 2; m_cv <= 1; end
        end
      end else if (m_st == 1) begin
        if (sar_ce) begin
          if (m_cnt == 2) begin m_st <= 2; m_cnt <= 0; m_cv <= 1; end
          else m_cnt <= m_cnt + 1;
        end
      end else if (sar_ce) begin
        if (fin) begin m_st <= 0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    string tr;
    tr = !lp_mode ? "R5" : (start_sel == 3'b010 ? "R8" : "R7");
    chk(tr, "track", track, exp_track());
    chk("R6", "busy", busy, m_st == 2);
    chk("R11", "convert", convert, m_cv);
    chk("R9", "done", done, m_done);
  endtask

  task automatic step();
    @(negedge clk);
    model_cmp();
  endtask

  task automatic clear_pulses();
    busy_we = 0; busy_wdata = 0; peer_start = 0; tmr3_ovf = 0; tmr2_ovf = 0; done_clr = 0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1", "track", track, 0); chk("R1", "convert", convert, 0);
    chk("R1", "busy", busy, 0);   chk("R1", "done", done, 0);
    rst_n = 1;
    step();

    // R2: disabled, every source pulsed
    sar_ce = 1;
    for (int s = 0; s < 5; s++) begin
      start_sel = 3'(s); busy_we = 1; busy_wdata = 1; peer_start = 1; tmr3_ovf = 1; tmr2_ovf = 1;
      ext_start = s[0];
      step();
      chk("R2", "busy off", busy, 0); chk("R2", "track off", track, 0);
    end
    clear_pulses(); ext_start = 0;
    en = 1; repeat (3) step();

    // R4: write of 0 ignored; write of 1 ignored off select 000
    start_sel = 3'b000; busy_we = 1; busy_wdata = 0; step();
    clear_pulses(); step(); chk("R4", "zero write", busy, 0);
    start_sel = 3'b001; busy_we = 1; busy_wdata = 1; step();
    clear_pulses(); step(); chk("R4", "write off-select", busy, 0);
    // R3: unselected source ignored, selected starts
    tmr2_ovf = 1; peer_start = 1; step(); clear_pulses();
    chk("R3", "unselected", busy, 0);
    chk("R5", "normal tracking", track, 1);
    tmr3_ovf = 1; step(); clear_pulses();
    chk("R3", "selected tmr3", busy, 1); chk("R11", "strobe", convert, 1);
    chk("R5", "track off in conv", track, 0);
    while (busy) step();
    step();

    // R6 and R10: conversion length with events arriving while busy
    start_sel = 3'b000; busy_we = 1; busy_wdata = 1; done_clr = 1; step();
    done_clr = 0;
    for (int i = 0; i < CONV_CLKS; i++) begin
      if (i > 0) begin @(negedge clk); model_cmp(); end
      chk("R6", "busy held", busy, 1);
      if (i == CONV_CLKS - 1) busy_we = 0;
    end
    step(); chk("R6", "busy fell", busy, 0); chk("R6", "done set", done, 1);
    step(); chk("R10", "not queued", busy, 0);
    repeat (4) step(); chk("R9", "sticky", done, 1);
    done_clr = 1; step(); done_clr = 0; chk("R9", "cleared", done, 0);

    // R7: low-power burst of three
    lp_mode = 1; start_sel = 3'b001; step();
    tmr3_ovf = 1; step(); tmr3_ovf = 0;
    chk("R7", "burst 1", track, 1); chk("R7", "no conv 1", busy, 0);
    tmr3_ovf = 1; step(); tmr3_ovf = 0;
    chk("R7", "burst 2", track, 1); chk("R10", "retrigger in burst", busy, 0);
    step(); chk("R7", "burst 3", track, 1);
    step(); chk("R7", "burst done", track, 0); chk("R7", "conv", busy, 1);
    chk("R11", "strobe lp", convert, 1);
    step(); chk("R11", "strobe one cycle", convert, 0);
    while (busy) step();

    // R8: pin-controlled tracking
    start_sel = 3'b010; ext_start = 0; repeat (3) step();
    chk("R8", "track pin low", track, 1);
    ext_start = 1; step(); chk("R8", "sync stage 1", track, 1);
    step(); chk("R8", "track off", track, 0); chk("R8", "not yet conv", busy, 0);
    step(); chk("R8", "conv on rise", busy, 1);
    while (busy) step();

    // R9: clear coinciding with completion keeps done set
    lp_mode = 0; start_sel = 3'b100; ext_start = 0; peer_start = 1; step(); peer_start = 0;
    for (int i = 1; i < CONV_CLKS; i++) step();
    done_clr = 1; step(); done_clr = 0;
    chk("R9", "set wins over clear", done, 1);
    chk("R6", "ended", busy, 0);

    // constrained random with model comparison
    for (int c = 0; c < 20000; c++) begin
      if (($urandom % 300) == 0) begin
        lp_mode = $urandom % 2; start_sel = 3'($urandom % 8);
      end
      en = ($urandom % 100) != 0;
      sar_ce = ($urandom % 2);
      busy_we = ($urandom % 20) == 0; busy_wdata = $urandom % 2;
      peer_start = ($urandom % 25) == 0;
      tmr3_ovf = ($urandom % 25) == 0;
      tmr2_ovf = ($urandom % 25) == 0;
      done_clr = ($urandom % 15) == 0;
      if (($urandom % 12) == 0) ext_start = ~ext_start;
      step();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule